// File: doc/BRIEF.md
# Quad Addressed Serial Setting Register Bank

This block is the digital control core of a four-channel programmable resistor. A host sends 8-bit words over a three-wire serial link made of a serial clock, an active-low select and a data line. While select is low, each rising serial clock edge shifts one bit into an internal word register. When select goes high again, the word is decoded. Its two leading bits name one of four channels, and its six trailing bits become that channel's new setting.

The serial inputs are sampled by a faster system clock and edge-detected. The serial output carries each bit eight serial clock edges after it entered, so several devices can share one select line in a chain. An active-low asynchronous reset puts every channel at midscale (0x20) and clears the output stage. An active-low shutdown input marks all channels as shut down and holds the serial output high. The stored settings survive shutdown, so they are in force again as soon as shutdown is released.

Top module: `qpot_core`

## Requirements
- R1: While `rst_n` is low, every channel code is 0x20 and `ser_dat_o` is 0 (given `shdn_n_i` high). This holds whatever the serial clock and select are doing.
- R2: A word is shifted in most-significant bit first. Word bits [7:6] are the channel address and bits [5:0] are the data. Address value k (0..3) writes channel k, which is the slice `code_o[k*6 +: 6]`.
- R3: A decoded write changes only the addressed channel. The other three channels keep their values.
- R4: Serial clock edges that occur while select is high leave the word register, `ser_dat_o` and all codes unchanged.
- R5: With shutdown released, `ser_dat_o` equals the bit shifted in eight serial clock rising edges earlier. If fewer than eight shifts have occurred since reset, it is 0.
- R6: While `shdn_n_i` is low, `ser_dat_o` is 1 and every bit of `shut_o` is 1. When `shdn_n_i` is high, `shut_o` is all 0. The codes are unaffected by shutdown and read the same after release.
- R7: If select rises after fewer than eight bits, the decode uses the word register as it stands. Older bits remain in the upper positions.
- R8: A channel code changes on the fourth system clock rising edge after the select line rises, and not on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial link |
| rst_n | input | 1 | Active-low asynchronous reset to midscale |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_sel_n_i | input | 1 | Active-low select; its rising edge commits a word |
| ser_dat_i | input | 1 | Serial data in |
| shdn_n_i | input | 1 | Active-low shutdown |
| ser_dat_o | output | 1 | Serial data out for chaining; high in shutdown |
| code_o | output | 24 | Four 6-bit channel codes, channel k at bits [k*6+5:k*6] |
| shut_o | output | 4 | Per-channel shutdown flag |

## Verification
Every serial edge crosses a two-stage synchronizer and then an edge detector. A shift therefore appears on the third system edge after a serial clock rise. The bench holds each serial clock level for four system cycles and samples `ser_dat_o` at the falling system edge at the end of the high phase. A select rise lands in a channel code on the fourth system edge. The bench checks the old code after three edges and the new code after the fourth. Shutdown and reset act on the outputs without a clock, so those checks are made one cycle after the input changes.

// File: rtl/qpot_pkg.sv
package qpot_pkg;
   localparam int unsigned QP_ADDR_W      = 2;
   localparam int unsigned QP_DATA_W      = 6;
   localparam int unsigned QP_SYNC_STAGES = 2;

   // bit positions of the serial inputs inside the synchronizer vector
   localparam int unsigned QP_IDX_CLK = 0;
   localparam int unsigned QP_IDX_SEL = 1;
   localparam int unsigned QP_IDX_DAT = 2;
   localparam int unsigned QP_IN_W    = 3;

   function automatic int unsigned qp_mid(input int unsigned w);
      return 32'd1 << (w - 1);
   endfunction
endpackage

// File: rtl/qpot_sync.sv
module qpot_sync #(
   parameter int unsigned    W       = 3,
   parameter int unsigned    STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] rise_o
);
   logic [STAGES-1:0][W-1:0] stg_q;
   logic [W-1:0]             prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qpot_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
         prev_q <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

   generate
      for (genvar b = 0; b < W; b++) begin : g_edge
         assign rise_o[b] = q_o[b] & ~prev_q[b];

         // R8
         rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[b] |=> !rise_o[b]);
      end
   endgenerate
endmodule

// File: rtl/qpot_shifter.sv
module qpot_shifter #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o,
   output logic              msb_o
);
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (shift_i) word_q <= {word_q[WORD_W-2:0], bit_i};
   end

   assign word_o = word_q;
   assign msb_o  = word_q[WORD_W-1];

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(word_q));

   // R5
   shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> (word_q[WORD_W-1:1] == $past(word_q[WORD_W-2:0])));
endmodule

// File: rtl/qpot_bank.sv
module qpot_bank #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 6,
   parameter int unsigned MID    = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_i,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [DATA_W-1:0]                data_i,
   output logic [(1<<ADDR_W)*DATA_W-1:0]    code_o
);
   localparam int unsigned N_CH = 1 << ADDR_W;
   localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(MID);

   logic [DATA_W-1:0] chan_q [N_CH];

   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_chan
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chan_q[i] <= MID_CODE;
            else if (wr_i && (addr_i == ADDR_W'(i)))
               chan_q[i] <= data_i;
         end
         assign code_o[i*DATA_W +: DATA_W] = chan_q[i];
      end
   endgenerate

   // R3
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(code_o));
endmodule

// File: rtl/qpot_core.sv
module qpot_core
   import qpot_pkg::*;
#(
   parameter int unsigned ADDR_W      = QP_ADDR_W,
   parameter int unsigned DATA_W      = QP_DATA_W,
   parameter int unsigned SYNC_STAGES = QP_SYNC_STAGES
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               ser_clk_i,
   input  logic                               ser_sel_n_i,
   input  logic                               ser_dat_i,
   input  logic                               shdn_n_i,
   output logic                               ser_dat_o,
   output logic [(1<<ADDR_W)*DATA_W-1:0]      code_o,
   output logic [(1<<ADDR_W)-1:0]             shut_o
);
   localparam int unsigned N_CH   = 1 << ADDR_W;
   localparam int unsigned WORD_W = ADDR_W + DATA_W;
   localparam int unsigned MID    = qp_mid(DATA_W);
   localparam logic [QP_IN_W-1:0] IN_RST = QP_IN_W'(1) << QP_IDX_SEL;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("qpot_core: ADDR_W must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("qpot_core: DATA_W must be at least 2");
      end
   endgenerate

   logic [QP_IN_W-1:0] raw_in, syn_q, syn_rise;
   logic               shift_en;
   logic [WORD_W-1:0]  word;
   logic               word_msb;
   logic               pend_v;
   logic [WORD_W-1:0]  pend_word;

   assign raw_in[QP_IDX_CLK] = ser_clk_i;
   assign raw_in[QP_IDX_SEL] = ser_sel_n_i;
   assign raw_in[QP_IDX_DAT] = ser_dat_i;

   qpot_sync #(
      .W       (QP_IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IN_RST)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (raw_in),
      .q_o    (syn_q),
      .rise_o (syn_rise)
   );

   assign shift_en = syn_rise[QP_IDX_CLK] & ~syn_q[QP_IDX_SEL];

   qpot_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift_en),
      .bit_i   (syn_q[QP_IDX_DAT]),
      .word_o  (word),
      .msb_o   (word_msb)
   );

   // hold the decoded word one cycle, then commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_word <= '0;
      end else begin
         pend_v <= syn_rise[QP_IDX_SEL];
         if (syn_rise[QP_IDX_SEL]) pend_word <= word;
      end
   end

   qpot_bank #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MID    (MID)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (pend_v),
      .addr_i (pend_word[WORD_W-1 -: ADDR_W]),
      .data_i (pend_word[DATA_W-1:0]),
      .code_o (code_o)
   );

   assign ser_dat_o = shdn_n_i ? word_msb : 1'b1;
   assign shut_o    = {N_CH{~shdn_n_i}};

   // R6
   sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_n_i |-> (ser_dat_o && (&shut_o)));

   // R8
   commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v |=> !pend_v);
endmodule

// File: tb/qpot_core_tb.sv
module qpot_core_tb;
   localparam int N_CH = 4;
   localparam int DW   = 6;

   logic clk = 1'b0;
   logic rst_n, sclk, sel_n, sdi, shdn_n;
   logic sdo;
   logic [N_CH*DW-1:0] code;
   logic [N_CH-1:0]    shut;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0]    m_sh;
   logic [DW-1:0] m_code [N_CH];

   always #10 clk = ~clk;

   qpot_core u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ser_clk_i   (sclk),
      .ser_sel_n_i (sel_n),
      .ser_dat_i   (sdi),
      .shdn_n_i    (shdn_n),
      .ser_dat_o   (sdo),
      .code_o      (code),
      .shut_o      (shut)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic exp_sdo();
      return shdn_n ? m_sh[7] : 1'b1;
   endfunction

   task automatic chk_codes(input string req);
      for (int i = 0; i < N_CH; i++)
         chk(req, 32'(code[i*DW +: DW]), 32'(m_code[i]));
      chk(req, 32'(shut), shdn_n ? 32'h0 : 32'hF);
   endtask

   task automatic send_bit(input logic b, input string req);
      sdi = b;
      tick(4);
      sclk = 1'b1;
      if (!sel_n) m_sh = {m_sh[6:0], b};
      tick(4);
      chk(req, 32'(sdo), 32'(exp_sdo()));
      sclk = 1'b0;
   endtask

   // shift nbits of w (msb first from bit nbits-1), then raise select
   task automatic frame(input logic [7:0] w, input int nbits, input bit timing);
      logic [1:0] a;
      sel_n = 1'b0;
      tick(4);
      for (int i = nbits - 1; i >= 0; i--) send_bit(w[i], "R5");
      tick(2);
      sel_n = 1'b1;
      a = m_sh[7:6];
      if (timing) begin
         tick(3);
         chk_codes("R8 before commit");
         m_code[a] = m_sh[5:0];
         tick(1);
         chk_codes("R8 at commit");
      end else begin
         m_code[a] = m_sh[5:0];
         tick(6);
         chk_codes("R2/R3 write");
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      m_sh = '0;
      for (int i = 0; i < N_CH; i++) m_code[i] = 6'h20;
      tick(1);
      chk_codes("R1 reset");
      chk("R1 sdo", 32'(sdo), 32'(exp_sdo()));
   endtask

   initial begin
      logic [7:0] w;
      logic [DW-1:0] snap [N_CH];
      logic          sdo_before;
      void'($urandom(32'd4711));
      rst_n = 1'b0; sclk = 1'b0; sel_n = 1'b1; sdi = 1'b0; shdn_n = 1'b1;
      do_reset();
      tick(2);
      rst_n = 1'b1;
      tick(3);
      chk_codes("R1 after release");

      // R2: each address once, distinct data; first frame checks R8 timing
      frame(8'b00_010101, 8, 1'b1);
      frame(8'b01_101010, 8, 1'b0);
      frame(8'b10_000000, 8, 1'b0);
      frame(8'b11_111111, 8, 1'b1);
      frame(8'b10_111110, 8, 1'b0);

      // R7: partial words keep older bits in upper positions
      frame(8'b0000_0011, 3, 1'b0);
      chk_codes("R7 partial");
      frame(8'b0000_0001, 1, 1'b0);
      chk_codes("R7 single bit");

      // R4: serial clock toggled with select high
      for (int i = 0; i < N_CH; i++) snap[i] = m_code[i];
      sdo_before = sdo;
      for (int k = 0; k < 10; k++) send_bit(1'($urandom()), "R4 sdo");
      chk("R4 sdo held", 32'(sdo), 32'(sdo_before));
      chk_codes("R4 codes");

      // R6: shutdown keeps codes, forces sdo high
      shdn_n = 1'b0;
      tick(1);
      chk("R6 sdo high", 32'(sdo), 32'h1);
      chk_codes("R6 in shutdown");
      shdn_n = 1'b1;
      tick(1);
      chk_codes("R6 after release");
      chk("R6 sdo back", 32'(sdo), 32'(m_sh[7]));

      // random traffic, occasionally partial or under shutdown
      for (int n = 0; n < 40; n++) begin
         w = 8'($urandom());
         shdn_n = ($urandom_range(0, 7) != 0);
         frame(w, ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 7)) : 8, n[2]);
      end
      shdn_n = 1'b1;
      tick(1);

      // R1: reset in the middle of a frame with serial clock high
      sel_n = 1'b0;
      tick(4);
      send_bit(1'b1, "R5");
      sclk = 1'b1;
      do_reset();
      sel_n = 1'b1;
      sclk = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(4);
      chk_codes("R1 mid-frame reset");
      chk("R1 sdo cleared", 32'(sdo), 32'h0);
      frame(8'b01_001100, 8, 1'b1);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule